// File: doc/BRIEF.md
# UART Transmit Register Block

This block is a memory-mapped serial transmitter for a debug console. A processor writes it over a plain 32-bit register bus. Before use, the driver resets the receive and transmit sides through encoded commands and selects one-byte-per-write mode. It then sets the transmitter enable. After that it hands characters to a transmit FIFO, one data-register write per character.

A serializer drains the FIFO onto a single line. Each character goes out as one start bit, eight data bits and one stop bit, and a programmable divider sets the bit period. Two status flags support the usual polling loops. The driver waits for "room" before each write, and waits for "all empty" before it resets the transmitter or hands the line elsewhere. A transmitter reset throws away anything still queued or in flight.

Top module: `stx_top`

## Requirements
- R1: After reset the status register reads 0x0C, the mode register reads 0, the divisor reads DIV_DEFAULT and the line `txd` is high.
- R2: Offset 0x03C holds the mode register, whose bit 4 is the only stored bit. Offset 0x0C0 holds the bit-period divisor in bits [15:0]. Both read back the value written. Offsets 0x0A8 and 0x100 read as zero.
- R3: While mode bit 4 is set, each write to offset 0x100 enqueues bits [7:0] as exactly one character. While mode bit 4 is clear, writes to 0x100 are ignored.
- R4: Status bit 2 (offset 0x0A4) is 1 whenever the FIFO holds fewer than DEPTH characters, and 0 when it is full.
- R5: Status bit 3 is 1 only when the FIFO is empty and no frame is being shifted out. The line is high whenever the flag is set.
- R6: Each character is sent as a frame: a low start bit, then data bits from LSB to MSB, then a high stop bit. Each bit lasts the programmed divisor number of clocks (a divisor of 0 counts as 1). Characters leave in write order, and the line idles high.
- R7: A command write (offset 0x0A8) with bit 2 set enables the transmitter. No start bit is driven while the transmitter is disabled.
- R8: A command write with code 2 in bits [6:4] resets the transmitter. It empties the FIFO, aborts any frame so the line is high on the next cycle, clears the enable and clears the overflow flag. Bit 2 of the same write enables the transmitter again.
- R9: Command bit 0 sets the receive-state flag (status bit 6). Command code 1 in bits [6:4] clears it and leaves the transmit side unchanged.
- R10: A data write in one-byte mode while the FIFO is full is dropped and sets status bit 7. Bit 7 stays set until a transmitter reset clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the read |
| txd | output | 1 | Serial output, idle high |

## Verification
The checker watches, on every cycle, the properties that tie the control state to the line. The line stays high while the transmitter is disabled or the empty flag is set. A transmitter reset leaves a high line and an empty FIFO one cycle later, and a receiver reset always clears the receive flag. A full-FIFO data write always raises the overflow flag, and the flag holds until a transmitter reset.

Other behaviour can only be shown by the bench's scenarios:
- frame contents and bit timing, character order, and dropped characters never reaching the line;
- the room flag falling exactly at the sixteenth entry;
- the contents discarded by a mid-frame reset never being sent later;
- data writes being ignored outside one-byte mode.

// File: rtl/stx_pkg.sv
// Package: register offsets, bit positions and command codes shared by
// the transmit register block and its checker.
package stx_pkg;
    localparam int unsigned ADDR_W = 12;

    localparam logic [ADDR_W-1:0] OFS_MODE = 12'h03C;
    localparam logic [ADDR_W-1:0] OFS_STAT = 12'h0A4;
    localparam logic [ADDR_W-1:0] OFS_CMD  = 12'h0A8;
    localparam logic [ADDR_W-1:0] OFS_DIV  = 12'h0C0;
    localparam logic [ADDR_W-1:0] OFS_DATA = 12'h100;

    localparam int unsigned MODE_ONECHAR_BIT = 4;
    localparam int unsigned STAT_ROOM_BIT    = 2;
    localparam int unsigned STAT_EMPTY_BIT   = 3;
    localparam int unsigned STAT_RXST_BIT    = 6;
    localparam int unsigned STAT_OVF_BIT     = 7;
    localparam int unsigned CMD_TXEN_BIT     = 2;
    localparam int unsigned CMD_RXARM_BIT    = 0;

    // Command code field in bits [6:4] of the command register
    typedef enum logic [2:0] {
        CODE_NONE     = 3'd0,
        CODE_RX_RESET = 3'd1,
        CODE_TX_RESET = 3'd2
    } stx_code_e;
endpackage

// File: rtl/stx_fifo.sv
// Module: stx_fifo
// Circular character queue with a synchronous clear.
// Assumes: the caller never pushes when full or pops when empty; the
// clear wins over a push or pop in the same cycle. Depth need not be a
// power of two.
module stx_fifo #(
    parameter int unsigned W     = 8,
    parameter int unsigned DEPTH = 16,
    localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic          empty,
    output logic          full,
    output logic [CW-1:0] count
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr_q, rd_ptr_q;
    logic [CW-1:0] cnt_q;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    // Storage write: no reset needed, validity is tracked by the count
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr_q] <= wdata;
    end

    // Pointer and occupancy tracking
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
        end else begin
            if (push) wr_ptr_q <= bump(wr_ptr_q);
            if (pop)  rd_ptr_q <= bump(rd_ptr_q);
            if (push && !pop)      cnt_q <= cnt_q + CW'(1);
            else if (pop && !push) cnt_q <= cnt_q - CW'(1);
        end
    end

    // Head and flag outputs
    always_comb begin
        rdata = mem[rd_ptr_q];
        empty = (cnt_q == '0);
        full  = (cnt_q == CW'(DEPTH));
        count = cnt_q;
    end
endmodule

// File: rtl/stx_shifter.sv
// Module: stx_shifter
// Frame serializer: takes one character when idle and enabled, sends a
// start bit, eight data bits LSB first and a stop bit, each held for
// `divisor` clocks (0 is treated as 1).
// Assumes: abort has priority over everything and leaves the line high.
module stx_shifter #(
    parameter int unsigned DIVW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            abort,
    input  logic            en,
    input  logic [DIVW-1:0] divisor,
    input  logic            avail,
    input  logic [7:0]      char_in,
    output logic            take,
    output logic            busy,
    output logic            txd
);
    logic            busy_q, txd_q;
    logic [8:0]      shreg_q;
    logic [3:0]      left_q;
    logic [DIVW-1:0] tick_q;
    logic [DIVW-1:0] div_eff;

    // Accept a character and clamp the divisor
    always_comb begin
        take    = !busy_q && en && avail && !abort;
        div_eff = (divisor == '0) ? DIVW'(1) : divisor;
    end

    // Bit timing and shifting
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            busy_q  <= 1'b0;
            txd_q   <= 1'b1;
            shreg_q <= '0;
            left_q  <= '0;
            tick_q  <= '0;
        end else if (take) begin
            busy_q  <= 1'b1;
            txd_q   <= 1'b0;
            shreg_q <= {1'b1, char_in};
            left_q  <= 4'd9;
            tick_q  <= div_eff - DIVW'(1);
        end else if (busy_q) begin
            if (tick_q == '0) begin
                if (left_q == '0) begin
                    busy_q <= 1'b0;
                end else begin
                    txd_q   <= shreg_q[0];
                    shreg_q <= {1'b1, shreg_q[8:1]};
                    left_q  <= left_q - 4'd1;
                    tick_q  <= div_eff - DIVW'(1);
                end
            end else begin
                tick_q <= tick_q - DIVW'(1);
            end
        end
    end

    // Outputs
    always_comb begin
        busy = busy_q;
        txd  = txd_q;
    end
endmodule

// File: rtl/stx_top.sv
// Module: stx_top
// Register front end of the serial transmitter: decodes the mode,
// status, command, divisor and data offsets, owns the control flags,
// and joins the FIFO to the serializer.
// Assumes: single-cycle register accesses with combinational read data;
// reads have no side effects.
module stx_top #(
    parameter int unsigned DEPTH       = 16,
    parameter int unsigned DIVW        = 16,
    parameter int unsigned DIV_DEFAULT = 16,
    localparam int unsigned CW         = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_we,
    input  logic [11:0] bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        txd
);
    import stx_pkg::*;

    logic            onechar_q, tx_en_q, rx_state_q, ovf_q;
    logic [DIVW-1:0] div_q;
    logic            wr, cmd_wr, data_wr, tx_clr, rx_clr, push;
    logic [2:0]      code;
    logic            fifo_empty, fifo_full, take, busy, st_empty;
    logic [7:0]      head;
    logic [CW-1:0]   fifo_cnt;
    logic            unused_hi;

    // Write strobes and command decode
    always_comb begin
        wr      = bus_sel && bus_we;
        cmd_wr  = wr && (bus_addr == OFS_CMD);
        data_wr = wr && (bus_addr == OFS_DATA) && onechar_q;
        code    = bus_wdata[6:4];
        tx_clr  = cmd_wr && (code == CODE_TX_RESET);
        rx_clr  = cmd_wr && (code == CODE_RX_RESET);
        push    = data_wr && !fifo_full;
        st_empty = fifo_empty && !busy;
    end

    assign unused_hi = ^bus_wdata[31:16];

    // Mode and divisor registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            onechar_q <= 1'b0;
            div_q     <= DIVW'(DIV_DEFAULT);
        end else if (wr) begin
            if (bus_addr == OFS_MODE) onechar_q <= bus_wdata[MODE_ONECHAR_BIT];
            if (bus_addr == OFS_DIV)  div_q     <= bus_wdata[DIVW-1:0];
        end
    end

    // Transmit enable: reset code reloads it from bit 2, otherwise bit 2 sets it
    always_ff @(posedge clk) begin
        if (!rst_n)                            tx_en_q <= 1'b0;
        else if (tx_clr)                       tx_en_q <= bus_wdata[CMD_TXEN_BIT];
        else if (cmd_wr && bus_wdata[CMD_TXEN_BIT]) tx_en_q <= 1'b1;
    end

    // Receive-state stub: armed by bit 0, cleared by the receiver reset code
    always_ff @(posedge clk) begin
        if (!rst_n || rx_clr)                          rx_state_q <= 1'b0;
        else if (cmd_wr && bus_wdata[CMD_RXARM_BIT])   rx_state_q <= 1'b1;
    end

    // Sticky overflow on a dropped data write
    always_ff @(posedge clk) begin
        if (!rst_n || tx_clr)           ovf_q <= 1'b0;
        else if (data_wr && fifo_full)  ovf_q <= 1'b1;
    end

    // Read data mux
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_we) begin
            case (bus_addr)
                OFS_MODE: bus_rdata[MODE_ONECHAR_BIT] = onechar_q;
                OFS_STAT: begin
                    bus_rdata[STAT_ROOM_BIT]  = !fifo_full;
                    bus_rdata[STAT_EMPTY_BIT] = st_empty;
                    bus_rdata[STAT_RXST_BIT]  = rx_state_q;
                    bus_rdata[STAT_OVF_BIT]   = ovf_q;
                end
                OFS_DIV:  bus_rdata[DIVW-1:0] = div_q;
                default:  bus_rdata = '0;
            endcase
        end
    end

    stx_fifo #(.W(8), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .clr(tx_clr),
        .push(push), .wdata(bus_wdata[7:0]),
        .pop(take), .rdata(head),
        .empty(fifo_empty), .full(fifo_full), .count(fifo_cnt)
    );

    stx_shifter #(.DIVW(DIVW)) u_shift (
        .clk(clk), .rst_n(rst_n), .abort(tx_clr), .en(tx_en_q),
        .divisor(div_q), .avail(!fifo_empty), .char_in(head),
        .take(take), .busy(busy), .txd(txd)
    );
endmodule

// File: rtl/stx_top_chk.sv
// Module: stx_top_chk
// Cycle-by-cycle properties of the transmit register block, bound into
// every instance of stx_top.
module stx_top_chk #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned CW    = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          txd,
    input logic          tx_en_q,
    input logic          tx_clr,
    input logic          rx_clr,
    input logic          rx_state_q,
    input logic          ovf_q,
    input logic          data_wr,
    input logic          fifo_full,
    input logic          st_empty,
    input logic [CW-1:0] fifo_cnt
);
    // R7
    tx_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en_q |-> txd);

    // R5
    empty_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_empty |-> txd);

    // R8
    tx_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_clr |=> (txd && fifo_cnt == '0));

    // R9
    rx_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_clr |=> !rx_state_q);

    // R10
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && fifo_full) |=> ovf_q);

    // R10
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !tx_clr) |=> ovf_q);

    // R4
    always_ff @(posedge clk) begin
        if (rst_n) fifo_bound_chk: assert (fifo_cnt <= CW'(DEPTH));
    end
endmodule

bind stx_top stx_top_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .txd(txd), .tx_en_q(tx_en_q),
    .tx_clr(tx_clr), .rx_clr(rx_clr), .rx_state_q(rx_state_q),
    .ovf_q(ovf_q), .data_wr(data_wr), .fifo_full(fifo_full),
    .st_empty(st_empty), .fifo_cnt(fifo_cnt)
);

// File: tb/stx_top_tb.sv
// Scoreboard bench: the driver queues each accepted character, a line
// monitor decodes frames off txd and compares them in order.
module stx_top_tb;
    localparam int DIVB = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        txd;

    int checks = 0, errors = 0, frames = 0;
    bit mon_on = 1'b1;
    bit done = 1'b0;
    logic [7:0] exp_q[$];

    always #4 clk = ~clk;

    stx_top u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .txd(txd)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic send(input logic [7:0] b);
        bus_write(12'h100, {24'h0, b});
        exp_q.push_back(b);
    endtask

    task automatic drain(input string req);
        logic [31:0] s;
        s = '0;
        for (int i = 0; i < 5000; i++) begin
            bus_read(12'h0A4, s);
            if (s[3]) break;
            repeat (6) @(posedge clk);
        end
        repeat (4) @(posedge clk);
        check(req, s[3], 1);
        check(req, exp_q.size(), 0);
    endtask

    // Monitor: decode frames mid-bit and compare against the queue (R6)
    always begin
        logic [7:0] got;
        @(negedge txd);
        if (mon_on && rst_n) begin
            repeat (DIVB / 2) @(posedge clk);
            #1 check("R6 start bit", txd, 0);
            for (int i = 0; i < 8; i++) begin
                repeat (DIVB) @(posedge clk);
                #1 got[i] = txd;
            end
            repeat (DIVB) @(posedge clk);
            #1 check("R6 stop bit", txd, 1);
            frames++;
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R6 unexpected frame: actual 0x%0h expected none", got);
            end else begin
                check("R6 frame data", got, exp_q.pop_front());
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        logic [31:0] r;
        int f0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        bus_read(12'h0A4, r); check("R1 status", r, 32'h0C);
        bus_read(12'h03C, r); check("R1 mode", r, 0);
        bus_read(12'h0C0, r); check("R1 divisor", r, 16);
        check("R1 txd", txd, 1);

        // R2: register readback and write-only offsets
        bus_write(12'h0C0, DIVB);
        bus_read(12'h0C0, r); check("R2 divisor", r, DIVB);
        bus_write(12'h03C, 32'hFFFF_FFFF);
        bus_read(12'h03C, r); check("R2 mode", r, 32'h10);
        bus_read(12'h100, r); check("R2 data reads 0", r, 0);

        // R7: queued but not enabled
        send(8'hA5);
        repeat (100) @(posedge clk);
        #1 check("R7 line idle while disabled", txd, 1);
        bus_read(12'h0A4, r); check("R5 not empty with queued char", r, 32'h04);

        // R6: several patterns in order after enabling
        bus_write(12'h0A8, 32'h04);
        send(8'h3C); send(8'h00); send(8'hFF); send(8'h81);
        drain("R6 drain");
        bus_read(12'h0A4, r); check("R5 empty after drain", r, 32'h0C);

        // R4 / R10: fill, overflow, sticky flag, dropped char never sent
        bus_write(12'h0A8, 32'h20);
        for (int i = 0; i < 15; i++) send(8'(i * 17 + 3));
        bus_read(12'h0A4, r); check("R4 room at 15", r[2], 1);
        send(8'hC7);
        bus_read(12'h0A4, r); check("R4 full at 16", r, 32'h00);
        bus_write(12'h100, 32'h99);
        bus_read(12'h0A4, r); check("R10 overflow set", r, 32'h80);
        bus_write(12'h0A8, 32'h04);
        drain("R10 drain after overflow");
        bus_read(12'h0A4, r); check("R10 overflow sticky", r, 32'h8C);
        bus_write(12'h0A8, 32'h20);
        bus_read(12'h0A4, r); check("R8 reset clears overflow", r, 32'h0C);

        // R3: data writes ignored outside one-char mode
        bus_write(12'h0A8, 32'h04);
        bus_write(12'h03C, 32'h0);
        bus_write(12'h100, 32'h77);
        bus_read(12'h0A4, r); check("R3 write ignored", r, 32'h0C);
        repeat (60) @(posedge clk);
        #1 check("R3 line idle", txd, 1);
        bus_write(12'h03C, 32'h10);

        // R9: receive-state stub
        bus_write(12'h0A8, 32'h01);
        bus_read(12'h0A4, r); check("R9 rx armed", r, 32'h4C);
        bus_write(12'h0A8, 32'h10);
        bus_read(12'h0A4, r); check("R9 rx cleared", r, 32'h0C);
        send(8'h5A);
        drain("R9 tx unaffected");

        // R8: reset mid-frame discards frame and queue
        mon_on = 1'b0;
        bus_write(12'h0A8, 32'h24);
        bus_write(12'h100, 32'h00);
        bus_write(12'h100, 32'h11);
        bus_write(12'h100, 32'h22);
        repeat (8) @(posedge clk);
        #1 check("R8 frame in progress", txd, 0);
        bus_write(12'h0A8, 32'h20);
        check("R8 line high after reset", txd, 1);
        bus_read(12'h0A4, r); check("R8 status after reset", r, 32'h0C);
        mon_on = 1'b1;
        f0 = frames;
        bus_write(12'h0A8, 32'h04);
        repeat (300) @(posedge clk);
        #1 check("R8 no stale frames", frames, f0);
        check("R8 line idle", txd, 1);

        done = 1'b1;
        report();
    end
endmodule